// File: doc/BRIEF.md
# Serial EEPROM Command Frontend

This block is the slave side of a three-wire serial EEPROM interface. It sits behind chip select, serial clock and serial data in, and it drives a data-out pin with a separate output enable. The enable lets the pad float when the block is not talking. Every pin is sampled with the block's own system clock, and a rising serial-clock edge is found by comparing the pin with its registered copy. After a start bit the block shifts in a 2-bit opcode, an address field whose first bit is ignored, and, for write-type instructions, one data word. It then decodes seven instructions: word read, word write, word erase, write enable, write disable, erase-all and write-all.

Reads go to a synchronous memory port. Data comes back one clock after a fetch strobe, and the block always fetches one word ahead. While chip select stays high the read keeps streaming words from the following addresses. Programming instructions are not carried out here. When chip select falls after a complete frame, the block hands the instruction to a separate programming sequencer as a one-cycle request. The block keeps a write-enable latch that gates that hand-off. It also reports ready or busy on the data pin while the sequencer works.

States: IDLE waits for the start bit. HDR shifts in opcode and address. DATA shifts in write data. RDOUT streams read data. DONE ignores all serial edges until chip select falls. Transitions: IDLE to HDR on a start bit. HDR to RDOUT for a read. HDR to DATA for write or write-all. HDR to DONE for erase, erase-all, enable and disable. DATA to DONE on the last data bit. Any state returns to IDLE whenever chip select is low.

Top module: `se_front`

## Requirements
- R1: While chip select is high and no frame is open, rising serial-clock edges with data in low are ignored. The first rising edge with data in high is the start bit.
- R2: Bits are sampled on rising serial-clock edges, MSB first. After the start bit come the opcode (2 bits) and the address field (ADDR_W+1 bits, first bit don't care). WRITE and write-all then take WORD_W data bits. With WORD_W=16, ADDR_W is 7; with WORD_W=8, ADDR_W is 8.
- R3: Opcode 10 is READ. On the edge that samples the last address bit, DO is driven to 0 (the dummy bit). Each following rising edge presents the next bit of the addressed word, MSB first.
- R4: While chip select stays high, READ carries on with the next address after every word and wraps from the top address to 0.
- R5: The write-enable latch is clear after reset. Opcode 00 with address-field top bits 11 sets it, and with 00 clears it. READ works in either latch state.
- R6: Opcode 01 (WRITE) with the latch set gives one prog_req_o pulse when chip select falls, with prog_op_o=0 and the frame's address and data.
- R7: Opcode 11 (ERASE) gives prog_op_o=1 with the address. Opcode 00 with top bits 10 (erase-all) gives prog_op_o=3. Opcode 00 with top bits 01 (write-all) gives prog_op_o=2 with its data word.
- R8: With the latch clear, no programming opcode raises prog_req_o.
- R9: A frame cut short by chip select falling produces nothing. Rising edges after the last required bit are ignored until chip select falls.
- R10: do_oe_o is low while chip select is low and while a header is being received. After a request has been issued, raising chip select before the next start bit drives DO to 0 while prog_busy_i is high and to 1 once it is low.
- R11: Chip select low returns control to IDLE, so a frame after an aborted one decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Data out enable (low = high impedance) |
| mem_rd_en_o | output | 1 | Array read strobe |
| mem_addr_o | output | ADDR_W | Array read address |
| mem_rdata_i | input | WORD_W | Array read data, valid one clock after the strobe |
| prog_req_o | output | 1 | One-cycle programming request |
| prog_op_o | output | 2 | 0 write, 1 erase, 2 write-all, 3 erase-all |
| prog_addr_o | output | ADDR_W | Programming address |
| prog_data_o | output | WORD_W | Programming data |
| prog_busy_i | input | 1 | Sequencer busy |

## Verification
The array is swept in full in one continuous read. This separates correct bit order and address increment from a wrap fault at the top address. A short read starting near the top, sent with the don't-care address bit set, checks framing and wrap on their own. Each programming opcode is sent once with the latch clear and once with it set, so gating faults show up separately from decode faults. Truncated frames, frames with extra trailing clocks, and aborted headers followed by a clean read test the framing boundaries. Status is polled during and after busy.

// File: rtl/se_pkg.sv
package se_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_DATA,
        S_RDOUT,
        S_DONE
    } fe_state_t;

    // opcode field following the start bit
    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_ERASE   = 2'b11;

    // sub-code in the top two address-field bits under OPC_SPECIAL
    localparam logic [1:0] SUB_LOCK    = 2'b00;
    localparam logic [1:0] SUB_FILL    = 2'b01;
    localparam logic [1:0] SUB_WIPE    = 2'b10;
    localparam logic [1:0] SUB_UNLOCK  = 2'b11;

    // request codes towards the programming sequencer
    localparam logic [1:0] PG_WRITE    = 2'd0;
    localparam logic [1:0] PG_ERASE    = 2'd1;
    localparam logic [1:0] PG_FILL     = 2'd2;
    localparam logic [1:0] PG_WIPE     = 2'd3;

endpackage

// File: rtl/se_edge.sv
module se_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_i,
    output logic sck_rise_o,
    output logic cs_fall_o
);

    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b0;
        end else begin
            sck_q <= sck_i;
            cs_q  <= cs_i;
        end
    end

    assign sck_rise_o = sck_i & ~sck_q;
    assign cs_fall_o  = cs_q & ~cs_i;

endmodule

// File: rtl/se_rdout.sv
module se_rdout #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              step_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              dout_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o
);

    localparam int BW = $clog2(WORD_W);

    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] nxt_q;
    logic [WORD_W-1:0] sh_q;
    logic [BW-1:0]     bcnt_q;
    logic              rd_en_q;
    logic              rd_q;
    logic              dout_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            nxt_q   <= '0;
            sh_q    <= '0;
            bcnt_q  <= '0;
            rd_en_q <= 1'b0;
            rd_q    <= 1'b0;
            dout_q  <= 1'b0;
        end else begin
            rd_en_q <= 1'b0;
            rd_q    <= rd_en_q;
            if (start_i) begin
                addr_q  <= addr_i;
                rd_en_q <= 1'b1;
                dout_q  <= 1'b0;
                bcnt_q  <= '0;
            end else if (step_i) begin
                if (bcnt_q == '0) begin
                    dout_q  <= nxt_q[WORD_W-1];
                    sh_q    <= {nxt_q[WORD_W-2:0], 1'b0};
                    bcnt_q  <= BW'(WORD_W-1);
                    rd_en_q <= 1'b1;
                end else begin
                    dout_q <= sh_q[WORD_W-1];
                    sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
                    bcnt_q <= bcnt_q - BW'(1);
                end
            end
            if (rd_q) begin
                nxt_q  <= mem_rdata_i;
                addr_q <= addr_q + ADDR_W'(1);
            end
        end
    end

    assign dout_o      = dout_q;
    assign mem_rd_en_o = rd_en_q;
    assign mem_addr_o  = addr_q;

    // R4
    fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_q |=> !rd_en_q);

endmodule

// File: rtl/se_wel.sv
module se_wel #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              pend_set_i,
    input  logic [1:0]        pend_op_i,
    input  logic [ADDR_W-1:0] pend_addr_i,
    input  logic [WORD_W-1:0] pend_data_i,
    input  logic              cs_fall_i,
    input  logic              start_seen_i,
    input  logic              busy_i,
    output logic              prog_req_o,
    output logic [1:0]        prog_op_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [WORD_W-1:0] prog_data_o,
    output logic              stat_arm_o
);

    logic              we_q;
    logic              pv_q;
    logic [1:0]        pop_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [WORD_W-1:0] pdata_q;
    logic              req_q;
    logic [1:0]        rop_q;
    logic [ADDR_W-1:0] raddr_q;
    logic [WORD_W-1:0] rdata_q;
    logic              stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            pv_q    <= 1'b0;
            pop_q   <= '0;
            paddr_q <= '0;
            pdata_q <= '0;
            req_q   <= 1'b0;
            rop_q   <= '0;
            raddr_q <= '0;
            rdata_q <= '0;
            stat_q  <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (en_set_i) we_q <= 1'b1;
            if (en_clr_i) we_q <= 1'b0;
            if (pend_set_i) begin
                pv_q    <= 1'b1;
                pop_q   <= pend_op_i;
                paddr_q <= pend_addr_i;
                pdata_q <= pend_data_i;
            end
            if (cs_fall_i) begin
                pv_q <= 1'b0;
                if (pv_q && we_q && !busy_i) begin
                    req_q   <= 1'b1;
                    rop_q   <= pop_q;
                    raddr_q <= paddr_q;
                    rdata_q <= pdata_q;
                    stat_q  <= 1'b1;
                end
            end
            if (start_seen_i) stat_q <= 1'b0;
        end
    end

    assign prog_req_o  = req_q;
    assign prog_op_o   = rop_q;
    assign prog_addr_o = raddr_q;
    assign prog_data_o = rdata_q;
    assign stat_arm_o  = stat_q;

    // R8
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |-> $past(we_q));

    // R6
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |=> !prog_req_o);

    // R9
    req_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |-> $past(cs_fall_i));

endmodule

// File: rtl/se_front.sv
module se_front #(
    parameter int WORD_W = 16,
    localparam int ADDR_W = (WORD_W == 16) ? 7 : 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sck_i,
    input  logic              di_i,
    output logic              do_o,
    output logic              do_oe_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              prog_req_o,
    output logic [1:0]        prog_op_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [WORD_W-1:0] prog_data_o,
    input  logic              prog_busy_i
);

    import se_pkg::*;

    localparam int AF_W    = ADDR_W + 1;
    localparam int HDR_W   = AF_W + 2;
    localparam int FLD_MAX = (HDR_W > WORD_W) ? HDR_W : WORD_W;
    localparam int CNT_W   = $clog2(FLD_MAX + 1);

    fe_state_t state_q, state_d;

    logic              sck_rise, cs_fall;
    logic [HDR_W-2:0]  hdr_q;
    logic [HDR_W-1:0]  hdr_nx;
    logic [WORD_W-2:0] wd_q;
    logic [WORD_W-1:0] wd_nx;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        dop_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [1:0]        opc, sub;
    logic [ADDR_W-1:0] fld_addr;
    logic              last_hdr, last_dat;
    logic              rd_dout, stat_arm;
    logic              en_set, en_clr, pend_set, rd_start, rd_step, start_seen;
    logic [1:0]        pend_op;
    logic [ADDR_W-1:0] pend_addr;
    logic [WORD_W-1:0] pend_data;

    se_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_i),
        .cs_i       (cs_i),
        .sck_rise_o (sck_rise),
        .cs_fall_o  (cs_fall)
    );

    assign hdr_nx   = {hdr_q, di_i};
    assign wd_nx    = {wd_q, di_i};
    assign opc      = hdr_nx[HDR_W-1 -: 2];
    assign sub      = hdr_nx[AF_W-1 -: 2];
    assign fld_addr = hdr_nx[ADDR_W-1:0];
    assign last_hdr = cs_i && sck_rise && (state_q == S_HDR)
                      && (cnt_q == CNT_W'(HDR_W-1));
    assign last_dat = cs_i && sck_rise && (state_q == S_DATA)
                      && (cnt_q == CNT_W'(WORD_W-1));

    // next state
    always_comb begin
        state_d = state_q;
        if (!cs_i) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:  if (sck_rise && di_i) state_d = S_HDR;
                S_HDR: begin
                    if (last_hdr) begin
                        if (opc == OPC_READ)
                            state_d = S_RDOUT;
                        else if (opc == OPC_WRITE)
                            state_d = S_DATA;
                        else if (opc == OPC_SPECIAL && sub == SUB_FILL)
                            state_d = S_DATA;
                        else
                            state_d = S_DONE;
                    end
                end
                S_DATA:  if (last_dat) state_d = S_DONE;
                S_RDOUT: state_d = S_RDOUT;
                S_DONE:  state_d = S_DONE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // field shifters and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q <= '0;
            wd_q  <= '0;
            cnt_q <= '0;
            dop_q <= '0;
            tgt_q <= '0;
        end else if (!cs_i) begin
            cnt_q <= '0;
        end else if (sck_rise) begin
            case (state_q)
                S_HDR: begin
                    hdr_q <= hdr_nx[HDR_W-2:0];
                    cnt_q <= last_hdr ? '0 : cnt_q + CNT_W'(1);
                    if (last_hdr) begin
                        tgt_q <= fld_addr;
                        dop_q <= (opc == OPC_WRITE) ? PG_WRITE : PG_FILL;
                    end
                end
                S_DATA: begin
                    wd_q  <= wd_nx[WORD_W-2:0];
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs and decode strobes
    always_comb begin
        en_set     = 1'b0;
        en_clr     = 1'b0;
        pend_set   = 1'b0;
        pend_op    = PG_WRITE;
        pend_addr  = fld_addr;
        pend_data  = wd_nx;
        rd_start   = 1'b0;
        start_seen = cs_i && sck_rise && di_i && (state_q == S_IDLE);
        rd_step    = cs_i && sck_rise && (state_q == S_RDOUT);
        if (last_hdr) begin
            unique case (opc)
                OPC_READ:  rd_start = 1'b1;
                OPC_ERASE: begin
                    pend_set = 1'b1;
                    pend_op  = PG_ERASE;
                end
                OPC_SPECIAL: begin
                    unique case (sub)
                        SUB_UNLOCK: en_set = 1'b1;
                        SUB_LOCK:   en_clr = 1'b1;
                        SUB_WIPE: begin
                            pend_set = 1'b1;
                            pend_op  = PG_WIPE;
                        end
                        SUB_FILL:   pend_set = 1'b0;
                    endcase
                end
                OPC_WRITE: pend_set = 1'b0;
            endcase
        end
        if (last_dat) begin
            pend_set  = 1'b1;
            pend_op   = dop_q;
            pend_addr = tgt_q;
        end
        do_oe_o = cs_i && ((state_q == S_RDOUT) || (state_q == S_IDLE && stat_arm));
        do_o    = (state_q == S_RDOUT) ? rd_dout : ~prog_busy_i;
    end

    se_rdout #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rdout (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (rd_start),
        .addr_i      (fld_addr),
        .step_i      (rd_step),
        .mem_rdata_i (mem_rdata_i),
        .dout_o      (rd_dout),
        .mem_rd_en_o (mem_rd_en_o),
        .mem_addr_o  (mem_addr_o)
    );

    se_wel #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_wel (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_set_i     (en_set),
        .en_clr_i     (en_clr),
        .pend_set_i   (pend_set),
        .pend_op_i    (pend_op),
        .pend_addr_i  (pend_addr),
        .pend_data_i  (pend_data),
        .cs_fall_i    (cs_fall),
        .start_seen_i (start_seen),
        .busy_i       (prog_busy_i),
        .prog_req_o   (prog_req_o),
        .prog_op_o    (prog_op_o),
        .prog_addr_o  (prog_addr_o),
        .prog_data_o  (prog_data_o),
        .stat_arm_o   (stat_arm)
    );

    // R1
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HDR && $past(state_q == S_IDLE)) |-> $past(di_i && cs_i));

    // R11
    cs_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> (state_q == S_IDLE));

    // R4
    fetch_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (state_q == S_RDOUT));

endmodule

// File: tb/se_front_bench.sv
module se_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, sck = 1'b0, di = 1'b0;
    logic        dout, doe, rd_en, preq, busy;
    logic [6:0]  raddr, paddr;
    logic [15:0] rdata, pdata;
    logic [1:0]  pop;

    int nchk = 0, nfail = 0;
    int req_cnt = 0, exp_req = 0;
    logic [1:0]  l_op;
    logic [6:0]  l_addr;
    logic [15:0] l_data;
    int          bcnt;
    logic [15:0] mem [128];
    logic [15:0] expm [128];
    logic        last_do, last_oe;

    always #10 clk = ~clk;

    se_front u_se_front (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di),
        .do_o(dout), .do_oe_o(doe),
        .mem_rd_en_o(rd_en), .mem_addr_o(raddr), .mem_rdata_i(rdata),
        .prog_req_o(preq), .prog_op_o(pop), .prog_addr_o(paddr),
        .prog_data_o(pdata), .prog_busy_i(busy)
    );

    function automatic logic [15:0] pat(int i);
        return 16'((i * 259) ^ 23100);
    endfunction

    // array and programming sequencer model
    always @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            bcnt <= 0;
            for (int i = 0; i < 128; i++) mem[i] <= pat(i);
        end else begin
            if (rd_en) rdata <= mem[raddr];
            if (preq) begin
                req_cnt <= req_cnt + 1;
                l_op <= pop; l_addr <= paddr; l_data <= pdata;
                busy <= 1'b1;
                bcnt <= 60;
            end else if (busy) begin
                if (bcnt == 0) begin
                    busy <= 1'b0;
                    case (l_op)
                        2'd0: mem[l_addr] <= l_data;
                        2'd1: mem[l_addr] <= 16'hFFFF;
                        2'd2: for (int i = 0; i < 128; i++) mem[i] <= l_data;
                        default: for (int i = 0; i < 128; i++) mem[i] <= 16'hFFFF;
                    endcase
                end else bcnt <= bcnt - 1;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        @(negedge clk) di = b;
        tick(2);
        sck = 1'b1;
        tick(3);
        last_do = dout;
        last_oe = doe;
        tick(1);
        sck = 1'b0;
        tick(2);
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [7:0] fld,
                          input logic [15:0] data, input int nd, input int extra);
        @(negedge clk) cs = 1'b1;
        tick(2);
        sbit(1'b1);
        sbit(op[1]); sbit(op[0]);
        for (int i = 7; i >= 0; i--) sbit(fld[i]);
        for (int i = 0; i < nd; i++) sbit(data[15-i]);
        repeat (extra) sbit(1'b1);
        @(negedge clk) begin cs = 1'b0; di = 1'b0; end
        tick(4);
    endtask

    task automatic wait_idle();
        tick(2);
        while (busy) tick(1);
        tick(2);
    endtask

    task automatic read_words(input logic [6:0] a, input int n, input logic dc);
        logic [15:0] w;
        @(negedge clk) cs = 1'b1;
        tick(2);
        repeat (3) sbit(1'b0);             // R1 clocks before start ignored
        sbit(1'b1);
        sbit(1'b1); sbit(1'b0);
        chk("R10 header oe", 32'(last_oe), 32'd0);
        sbit(dc);                           // R2 don't-care bit
        for (int i = 6; i >= 0; i--) sbit(a[i]);
        chk("R3 dummy bit", {30'd0, last_oe, last_do}, 32'h2);
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int b = 0; b < 16; b++) begin
                sbit(1'b0);
                w = {w[14:0], last_do};
            end
            if (k == 0) chk("R3 word", 32'(w), 32'(expm[a]));
            else chk("R4 stream", 32'(w), 32'(expm[7'(a + 7'(k))]));
        end
        @(negedge clk) cs = 1'b0;
        tick(2);
        chk("R10 cs low oe", 32'(doe), 32'd0);
    endtask

    task automatic expect_req(input string req, input logic [1:0] op,
                              input logic [6:0] a, input logic [15:0] d, input logic use_d);
        exp_req++;
        chk(req, 32'(req_cnt), 32'(exp_req));
        chk(req, 32'(l_op), 32'(op));
        if (op < 2) chk(req, 32'(l_addr), 32'(a));
        if (use_d) chk(req, 32'(l_data), 32'(d));
    endtask

    initial begin
        for (int i = 0; i < 128; i++) expm[i] = pat(i);
        tick(5);
        chk("R10 reset oe", 32'(doe), 32'd0);
        chk("R6 reset req", 32'(preq), 32'd0);
        rst_n = 1'b1;
        tick(3);

        read_words(7'd0, 130, 1'b0);         // R3 R4 full sweep plus wrap
        read_words(7'd125, 5, 1'b1);         // R4 wrap, R2 don't care

        // R8 programming with latch clear
        do_cmd(2'b01, 8'd5, 16'hBEEF, 16, 0);
        do_cmd(2'b11, 8'd6, 16'h0, 0, 0);
        do_cmd(2'b00, 8'b1000_0000, 16'h0, 0, 0);
        do_cmd(2'b00, 8'b0100_0000, 16'h1234, 16, 0);
        wait_idle();
        chk("R8 no request", 32'(req_cnt), 32'(exp_req));
        read_words(7'd5, 2, 1'b0);           // R8 contents unchanged

        // R5 enable, R6 write
        do_cmd(2'b00, 8'b1100_0000, 16'h0, 0, 0);
        do_cmd(2'b01, 8'd5, 16'hBEEF, 16, 0);
        expect_req("R6 write", 2'd0, 7'd5, 16'hBEEF, 1'b1);
        @(negedge clk) cs = 1'b1;
        tick(3);
        chk("R10 busy status", {30'd0, doe, dout}, 32'h2);
        while (busy) tick(1);
        tick(2);
        chk("R10 ready status", {30'd0, doe, dout}, 32'h3);
        @(negedge clk) cs = 1'b0;
        tick(3);
        expm[5] = 16'hBEEF;
        read_words(7'd4, 3, 1'b0);

        // R7 erase word
        do_cmd(2'b11, 8'd9, 16'h0, 0, 0);
        expect_req("R7 erase", 2'd1, 7'd9, 16'h0, 1'b0);
        wait_idle();
        expm[9] = 16'hFFFF;
        read_words(7'd9, 1, 1'b0);

        // R9 truncated frame, R11 aborted header then clean frame
        do_cmd(2'b01, 8'd30, 16'h1111, 10, 0);
        @(negedge clk) cs = 1'b1;
        tick(2);
        sbit(1'b1); sbit(1'b0); sbit(1'b1);
        @(negedge clk) cs = 1'b0;
        tick(3);
        chk("R9 truncated", 32'(req_cnt), 32'(exp_req));
        read_words(7'd30, 1, 1'b0);          // R11
        read_words(7'd5, 1, 1'b0);           // R11

        // R9 extra trailing clocks ignored
        do_cmd(2'b01, 8'd20, 16'h1234, 16, 5);
        expect_req("R9 trailing", 2'd0, 7'd20, 16'h1234, 1'b1);
        wait_idle();
        expm[20] = 16'h1234;
        read_words(7'd20, 1, 1'b0);

        // R7 erase-all then write-all
        do_cmd(2'b00, 8'b1000_0000, 16'h0, 0, 0);
        expect_req("R7 erase-all", 2'd3, 7'd0, 16'h0, 1'b0);
        wait_idle();
        for (int i = 0; i < 128; i++) expm[i] = 16'hFFFF;
        read_words(7'd60, 3, 1'b0);
        do_cmd(2'b00, 8'b0100_0000, 16'hA5C3, 16, 0);
        expect_req("R7 write-all", 2'd2, 7'd0, 16'hA5C3, 1'b1);
        wait_idle();
        for (int i = 0; i < 128; i++) expm[i] = 16'hA5C3;
        read_words(7'd0, 128, 1'b0);

        // R5 disable again: write ignored, read still works
        do_cmd(2'b00, 8'b0000_0000, 16'h0, 0, 0);
        do_cmd(2'b01, 8'd7, 16'h0F0F, 16, 0);
        wait_idle();
        chk("R5 disabled write", 32'(req_cnt), 32'(exp_req));
        read_words(7'd7, 1, 1'b0);

        summary();
        $finish;
    end

endmodule